// File: doc/BRIEF.md
# Segment Selector Translation Unit

This block turns a logical address, made of a 16-bit selector and a 32-bit offset, into a 32-bit linear address. It holds six segment registers. Each one caches the 8-byte descriptor that was fetched for it, along with the privilege field of the selector that loaded it. Software-visible loading happens through a load port. The port takes a segment-register number and a selector, forms the descriptor address in either the local or the global descriptor table, and issues one read on a simple request/response memory interface. The response then fills the segment register.

Translation takes a segment-register number and an offset. The offset is compared against the cached limit. A valid offset is added to the cached base, and the sum wraps modulo 2^32. If the offset exceeds the limit, or the segment register has never been loaded, the result is a fault instead of an address. The linear address is not paged here.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `xl_done_o`, `xl_fault_o`, `mem_req_o` and `load_busy_o` are low, and every segment register is unloaded.
- R2: The selector layout is index in bits [15:3], table select in bit [2] (1 = local table, 0 = global table) and privilege in bits [1:0]. The fetch address is the chosen table base plus index times 8, modulo 2^32.
- R3: An accepted load drives `mem_req_o` and `load_busy_o` high from the next cycle until the cycle in which `mem_rsp_valid_i` is seen. `mem_addr_o` stays constant during that time, and load requests arriving during it are ignored.
- R4: The response word is decoded as base = bits [31:0] and limit = bits [63:32]. The response marks the target segment register as loaded, and a later load of the same register replaces its contents.
- R5: `xl_done_o` is high in exactly the cycle after a cycle with `xl_valid_i` high, and low otherwise.
- R6: When offset <= limit on a loaded register, `xl_fault_o` is 0 and `xl_lin_o` = base + offset modulo 2^32. `xl_priv_o` then gives the privilege bits of the selector that loaded the register.
- R7: When offset > limit, `xl_fault_o` is 1 and `xl_lin_o` is 0.
- R8: Translating through a segment register that has not been loaded since reset raises `xl_fault_o`.
- R9: Segment-register numbers 6 and 7 are invalid. A load to them issues no memory request, and a translate through them faults.
- R10: If a load response and a translate to the same segment register fall in the same cycle, the translate uses the contents from before that load.
- R11: Loading one segment register leaves the translations of all other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ldt_base_i | input | 32 | Base address of the local descriptor table |
| gdt_base_i | input | 32 | Base address of the global descriptor table |
| load_valid_i | input | 1 | Request to load a segment register |
| load_seg_i | input | 3 | Segment register to load |
| load_sel_i | input | 16 | Selector to load |
| load_busy_o | output | 1 | A descriptor fetch is outstanding |
| mem_req_o | output | 1 | Descriptor read request, held until response |
| mem_addr_o | output | 32 | Descriptor byte address |
| mem_rsp_valid_i | input | 1 | Descriptor read data is valid |
| mem_rsp_data_i | input | 64 | Descriptor read data |
| xl_valid_i | input | 1 | Translate request |
| xl_seg_i | input | 3 | Segment register used for translation |
| xl_off_i | input | 32 | Offset within the segment |
| xl_done_o | output | 1 | Translation result valid |
| xl_lin_o | output | 32 | Linear address, 0 on fault |
| xl_fault_o | output | 1 | Limit violation, unloaded or invalid segment |
| xl_priv_o | output | 2 | Privilege field recorded for the segment |

## Verification
The load response can write a segment register in the same cycle that a translate reads it. The bench provokes this on every load by raising `xl_valid_i` in the very cycle it presents `mem_rsp_valid_i` for the same register. It judges the result against the mapping held before that load. On a first load this means a fault, and on a reload it means the old base, limit and privilege. Afterwards a follow-up translate confirms that the new mapping has taken effect.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int ADDR_W    = 32;
    localparam int SEL_W     = 16;
    localparam int PRIV_W    = 2;
    localparam int IDX_W     = SEL_W - PRIV_W - 1;
    localparam int DESC_W    = 2 * ADDR_W;
    localparam int DESC_SH   = 3;
    localparam int SEG_COUNT = 6;
    localparam int SEG_W     = $clog2(SEG_COUNT);

    typedef struct packed {
        logic [IDX_W-1:0]  index;
        logic              use_local;
        logic [PRIV_W-1:0] priv;
    } selector_t;

    typedef struct packed {
        logic [ADDR_W-1:0] limit;
        logic [ADDR_W-1:0] base;
    } descriptor_t;

    typedef struct packed {
        logic              loaded;
        logic [PRIV_W-1:0] priv;
        descriptor_t       desc;
    } seg_entry_t;

    typedef enum logic [0:0] {
        LD_IDLE = 1'b0,
        LD_WAIT = 1'b1
    } ld_state_e;

    function automatic logic [ADDR_W-1:0] desc_addr(
        input selector_t         s,
        input logic [ADDR_W-1:0] local_base,
        input logic [ADDR_W-1:0] global_base
    );
        logic [ADDR_W-1:0] tbl;
        logic [ADDR_W-1:0] ofs;
        tbl = s.use_local ? local_base : global_base;
        ofs = {{(ADDR_W-IDX_W-DESC_SH){1'b0}}, s.index, {DESC_SH{1'b0}}};
        return tbl + ofs;
    endfunction

    function automatic logic seg_in_range(input logic [SEG_W-1:0] seg);
        return 32'(seg) < SEG_COUNT;
    endfunction

endpackage

// File: rtl/seg_loader.sv
module seg_loader
    import seg_xlate_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   ldt_base,
    input  logic [ADDR_W-1:0]   gdt_base,
    input  logic                load_valid,
    input  logic [SEG_W-1:0]    load_seg,
    input  logic [SEL_W-1:0]    load_sel,
    input  logic                rsp_valid,
    input  logic [DESC_W-1:0]   rsp_data,
    output logic                busy,
    output logic                req,
    output logic [ADDR_W-1:0]   req_addr,
    output logic                wr_en,
    output logic [SEG_W-1:0]    wr_seg,
    output seg_entry_t          wr_entry
);

    ld_state_e          state_q;
    logic [SEG_W-1:0]   seg_q;
    logic [PRIV_W-1:0]  priv_q;
    logic [ADDR_W-1:0]  addr_q;
    selector_t          sel_in;
    logic               accept;

    assign sel_in = selector_t'(load_sel);
    assign accept = (state_q == LD_IDLE) && load_valid && seg_in_range(load_seg);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LD_IDLE;
            seg_q   <= '0;
            priv_q  <= '0;
            addr_q  <= '0;
        end else begin
            case (state_q)
                LD_IDLE: if (accept) begin
                    state_q <= LD_WAIT;
                    seg_q   <= load_seg;
                    priv_q  <= sel_in.priv;
                    addr_q  <= desc_addr(sel_in, ldt_base, gdt_base);
                end
                LD_WAIT: if (rsp_valid) begin
                    state_q <= LD_IDLE;
                end
                default: state_q <= LD_IDLE;
            endcase
        end
    end

    assign req           = (state_q == LD_WAIT);
    assign busy          = req;
    assign req_addr      = addr_q;
    assign wr_en         = req && rsp_valid;
    assign wr_seg        = seg_q;
    assign wr_entry.loaded = 1'b1;
    assign wr_entry.priv   = priv_q;
    assign wr_entry.desc   = descriptor_t'(rsp_data);

endmodule

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_seg,
    input  seg_entry_t       wr_entry,
    input  logic [SEG_W-1:0] rd_seg,
    output seg_entry_t       rd_entry
);

    seg_entry_t entries_q [SEG_COUNT];

    for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) begin
                entries_q[g] <= '0;
            end else if (wr_en && (wr_seg == SEG_W'(g))) begin
                entries_q[g] <= wr_entry;
            end
        end
    end

    always_comb begin
        rd_entry = '0;
        for (int i = 0; i < SEG_COUNT; i++) begin
            if (rd_seg == SEG_W'(i)) rd_entry = entries_q[i];
        end
    end

endmodule

// File: rtl/seg_limit_add.sv
module seg_limit_add
    import seg_xlate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               valid,
    input  seg_entry_t         entry,
    input  logic [ADDR_W-1:0]  offset,
    output logic               done,
    output logic [ADDR_W-1:0]  lin,
    output logic               fault,
    output logic [PRIV_W-1:0]  priv
);

    logic              ok;
    logic [ADDR_W-1:0] sum;

    assign ok  = entry.loaded && (offset <= entry.desc.limit);
    assign sum = entry.desc.base + offset;

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            lin   <= '0;
            fault <= 1'b0;
            priv  <= '0;
        end else begin
            done  <= valid;
            lin   <= (valid && ok) ? sum : '0;
            fault <= valid && !ok;
            priv  <= valid ? entry.priv : '0;
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       ldt_base_i,
    input  logic [31:0]       gdt_base_i,
    input  logic              load_valid_i,
    input  logic [2:0]        load_seg_i,
    input  logic [15:0]       load_sel_i,
    output logic              load_busy_o,
    output logic              mem_req_o,
    output logic [31:0]       mem_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [63:0]       mem_rsp_data_i,
    input  logic              xl_valid_i,
    input  logic [2:0]        xl_seg_i,
    input  logic [31:0]       xl_off_i,
    output logic              xl_done_o,
    output logic [31:0]       xl_lin_o,
    output logic              xl_fault_o,
    output logic [1:0]        xl_priv_o
);

    logic             wr_en;
    logic [SEG_W-1:0] wr_seg;
    seg_entry_t       wr_entry;
    seg_entry_t       rd_entry;

    seg_loader u_loader (
        .clk       (clk),
        .rst       (rst),
        .ldt_base  (ldt_base_i),
        .gdt_base  (gdt_base_i),
        .load_valid(load_valid_i),
        .load_seg  (load_seg_i),
        .load_sel  (load_sel_i),
        .rsp_valid (mem_rsp_valid_i),
        .rsp_data  (mem_rsp_data_i),
        .busy      (load_busy_o),
        .req       (mem_req_o),
        .req_addr  (mem_addr_o),
        .wr_en     (wr_en),
        .wr_seg    (wr_seg),
        .wr_entry  (wr_entry)
    );

    seg_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_seg  (wr_seg),
        .wr_entry(wr_entry),
        .rd_seg  (xl_seg_i),
        .rd_entry(rd_entry)
    );

    seg_limit_add u_xl (
        .clk   (clk),
        .rst   (rst),
        .valid (xl_valid_i),
        .entry (rd_entry),
        .offset(xl_off_i),
        .done  (xl_done_o),
        .lin   (xl_lin_o),
        .fault (xl_fault_o),
        .priv  (xl_priv_o)
    );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_xlate_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        load_valid_i,
    input logic [2:0]  load_seg_i,
    input logic        load_busy_o,
    input logic        mem_req_o,
    input logic [31:0] mem_addr_o,
    input logic        mem_rsp_valid_i,
    input logic        xl_valid_i,
    input logic [2:0]  xl_seg_i,
    input logic        xl_done_o,
    input logic [31:0] xl_lin_o,
    input logic        xl_fault_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!xl_done_o && !xl_fault_o && !mem_req_o && !load_busy_o));

    // R5
    done_follows_chk: assert property (@(posedge clk) disable iff (rst)
        xl_valid_i |=> xl_done_o);

    // R5
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
        !xl_valid_i |=> !xl_done_o);

    // R7
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        xl_fault_o |-> (xl_done_o && xl_lin_o == 32'h0));

    // R3
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_rsp_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R3
    busy_req_match_chk: assert property (@(posedge clk) disable iff (rst)
        load_busy_o == mem_req_o);

    // R9
    bad_load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_busy_o && load_valid_i && 32'(load_seg_i) >= SEG_COUNT) |=> !mem_req_o);

    // R9
    bad_xlate_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (xl_valid_i && 32'(xl_seg_i) >= SEG_COUNT) |=> xl_fault_o);

endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;

    localparam int PERIOD = 10;
    localparam int LAT    = 3;
    localparam logic [31:0] LDT_BASE = 32'h0001_2000;
    localparam logic [31:0] GDT_BASE = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_valid_i = 1'b0;
    logic [2:0]  load_seg_i = '0;
    logic [15:0] load_sel_i = '0;
    logic        load_busy_o;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_rsp_valid_i = 1'b0;
    logic [63:0] mem_rsp_data_i = '0;
    logic        xl_valid_i = 1'b0;
    logic [2:0]  xl_seg_i = '0;
    logic [31:0] xl_off_i = '0;
    logic        xl_done_o;
    logic [31:0] xl_lin_o;
    logic        xl_fault_o;
    logic [1:0]  xl_priv_o;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_base [6];
    logic [31:0] m_lim  [6];
    logic [1:0]  m_priv [6];
    logic        m_ld   [6];

    always #(PERIOD/2) clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst(rst),
        .ldt_base_i(LDT_BASE), .gdt_base_i(GDT_BASE),
        .load_valid_i(load_valid_i), .load_seg_i(load_seg_i), .load_sel_i(load_sel_i),
        .load_busy_o(load_busy_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
        .xl_valid_i(xl_valid_i), .xl_seg_i(xl_seg_i), .xl_off_i(xl_off_i),
        .xl_done_o(xl_done_o), .xl_lin_o(xl_lin_o), .xl_fault_o(xl_fault_o),
        .xl_priv_o(xl_priv_o)
    );

    function automatic logic [31:0] mk_base(input logic [31:0] a);
        return a ^ 32'hFFFF_F000;
    endfunction

    function automatic logic [31:0] mk_lim(input logic [31:0] a);
        return {16'h0, a[15:0] ^ 16'hFFFF};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One translate; outputs sampled at the following negedge.
    task automatic xlate_chk(input int seg, input logic [31:0] off, input string tag);
        logic [31:0] e_lin;
        bit          e_flt;
        @(negedge clk);
        xl_valid_i = 1'b1; xl_seg_i = 3'(seg); xl_off_i = off;
        @(negedge clk);
        xl_valid_i = 1'b0;
        e_flt = (seg > 5) ? 1'b1 : (!m_ld[seg] || off > m_lim[seg]);
        e_lin = e_flt ? 32'h0 : m_base[seg] + off;
        chk(xl_done_o === 1'b1, {tag, " R5 done"}, 64'(xl_done_o), 64'd1);
        chk(xl_fault_o === e_flt, {tag, " fault"}, 64'(xl_fault_o), 64'(e_flt));
        chk(xl_lin_o === e_lin, {tag, " linear"}, 64'(xl_lin_o), 64'(e_lin));
        if (!e_flt)
            chk(xl_priv_o === m_priv[seg], {tag, " R6 priv"}, 64'(xl_priv_o), 64'(m_priv[seg]));
    endtask

    task automatic sweep_all(input string tag);
        for (int s = 0; s < 6; s++) begin
            if (m_ld[s]) begin
                xlate_chk(s, 32'h0, {tag, " R6 zero"});
                xlate_chk(s, m_lim[s] - 1, {tag, " R6 below"});
                xlate_chk(s, m_lim[s], {tag, " R6 at limit"});
                xlate_chk(s, m_lim[s] + 1, {tag, " R7 over"});
                xlate_chk(s, 32'hFFFF_FFFF, {tag, " R7 max"});
            end else begin
                xlate_chk(s, 32'h0, {tag, " R8 unloaded"});
            end
        end
    endtask

    // Load a segment; the translate in the response cycle must see old contents (R10).
    task automatic do_load(input int seg, input logic [15:0] sel, input bit intrude);
        logic [31:0] e_addr;
        logic [31:0] o_lin;
        bit          o_flt;
        e_addr = (sel[2] ? LDT_BASE : GDT_BASE) + {16'h0, sel[15:3], 3'b000};
        @(negedge clk);
        load_valid_i = 1'b1; load_seg_i = 3'(seg); load_sel_i = sel;
        @(negedge clk);
        load_valid_i = 1'b0;
        chk(mem_req_o === 1'b1 && load_busy_o === 1'b1, "R3 req raised", 64'(mem_req_o), 64'd1);
        chk(mem_addr_o === e_addr, "R2 fetch address", 64'(mem_addr_o), 64'(e_addr));
        for (int k = 0; k < LAT; k++) begin
            if (intrude && k == 0) begin
                load_valid_i = 1'b1; load_seg_i = 3'd5; load_sel_i = 16'hFFFF;
            end
            @(negedge clk);
            load_valid_i = 1'b0;
            chk(mem_req_o === 1'b1 && mem_addr_o === e_addr, "R3 req held",
                64'(mem_addr_o), 64'(e_addr));
        end
        // response and same-segment translate in one cycle
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = {mk_lim(e_addr), mk_base(e_addr)};
        xl_valid_i = 1'b1; xl_seg_i = 3'(seg); xl_off_i = 32'h10;
        o_flt = !m_ld[seg] || 32'h10 > m_lim[seg];
        o_lin = o_flt ? 32'h0 : m_base[seg] + 32'h10;
        @(negedge clk);
        mem_rsp_valid_i = 1'b0; xl_valid_i = 1'b0;
        chk(xl_fault_o === o_flt, "R10 old fault", 64'(xl_fault_o), 64'(o_flt));
        chk(xl_lin_o === o_lin, "R10 old linear", 64'(xl_lin_o), 64'(o_lin));
        chk(mem_req_o === 1'b0 && load_busy_o === 1'b0, "R3 req dropped", 64'(mem_req_o), 64'd0);
        m_base[seg] = mk_base(e_addr);
        m_lim[seg]  = mk_lim(e_addr);
        m_priv[seg] = sel[1:0];
        m_ld[seg]   = 1'b1;
        xlate_chk(seg, 32'h10, "R4 new mapping");
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < 6; s++) begin
            m_base[s] = '0; m_lim[s] = '0; m_priv[s] = '0; m_ld[s] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(xl_done_o === 1'b0 && xl_fault_o === 1'b0, "R1 xlate idle", 64'(xl_done_o), 64'd0);
        chk(mem_req_o === 1'b0 && load_busy_o === 1'b0, "R1 loader idle", 64'(mem_req_o), 64'd0);
        for (int s = 0; s < 8; s++) xlate_chk(s, 32'h0, "R1 R8 R9 unloaded");

        // R9: invalid segment number issues no request
        @(negedge clk);
        load_valid_i = 1'b1; load_seg_i = 3'd6; load_sel_i = 16'h0008;
        @(negedge clk);
        load_valid_i = 1'b0;
        chk(mem_req_o === 1'b0 && load_busy_o === 1'b0, "R9 load seg 6", 64'(mem_req_o), 64'd0);
        load_valid_i = 1'b1; load_seg_i = 3'd7;
        @(negedge clk);
        load_valid_i = 1'b0;
        chk(mem_req_o === 1'b0, "R9 load seg 7", 64'(mem_req_o), 64'd0);

        // First round: each segment, alternating tables and privilege values.
        for (int s = 0; s < 6; s++) begin
            logic [15:0] sel;
            sel = {13'(s * 37), s[0], 2'(s)};
            do_load(s, sel, s == 0);
            if (s == 0) xlate_chk(5, 32'h0, "R3 intruding load ignored");
        end
        sweep_all("round1");
        // Wrap case: segment 0 uses global index 0, base 0xFFFFF100, limit 0xFEFF.
        xlate_chk(0, 32'h0000_FE00, "R6 wrap");

        // Reload segment 2; others must keep their mappings (R11).
        do_load(2, {13'd1000, 1'b1, 2'd3}, 1'b0);
        do_load(4, {13'd8191, 1'b0, 2'd1}, 1'b0);
        sweep_all("R11 round2");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule